// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

A small, fully associative table of segment descriptors. Each slot pairs an effective-segment word, which carries the segment tag and a valid flag, with a virtual-segment word. The virtual-segment word carries the segment size, the protection keys, a no-execute flag and a page-size code. A dedicated lookup port compares an effective address against every slot in the same cycle and registers the result: hit, slot number and segment word. When more than one slot matches, the lowest-numbered slot is selected.

A command port handles maintenance. It can write a slot, after checking the operands for illegal field combinations. It can read back either word of a slot, find the segment word for an address, invalidate the slot that covers an address, or invalidate every slot except slot 0. Invalidations that actually remove a valid entry raise a one-cycle request to flush cached translations, either for this processor or for all processors.

Word layout. The effective-segment word holds the tag in bits 63:28 and the valid flag in bit 27; bits 26:0 are zero. The virtual-segment word holds the size field in bits 63:62 (0 = 256 MB, 1 = 1 TB) and the page-size code in bits 7:4. The other bits are stored as given.

Top module: `slb_array`

## Requirements
- R1: After reset every slot reads as zero on both words, and every lookup misses.
- R2: A lookup whose address selects the same 256 MB segment as a valid slot with size 0 reports, one clock later, hit=1, the slot number and that slot's segment word. A miss reports hit=0, slot 0 and a zero word.
- R3: A slot with size 1 matches any address whose bits 63:40 equal its tag bits 63:40. In that case the tag's bits 39:28 must be zero.
- R4: When several slots match, the lowest-numbered one is reported.
- R5: Command op 0 (write) takes the slot from operand A bits 11:0, the tag word from A with bits 11:0 cleared, and the segment word from operand B. A slot number not below NSLOTS returns an error and changes nothing.
- R6: A write is also rejected, with no state change, when any of the following holds: A bits 26:12 are not zero; B bit 63 is set; B bit 62 is set while en_1t is low; or B bits 7:4 match no entry of the page-size table.
- R7: Op 1 returns the tag word and op 2 returns the segment word of the slot in A bits 11:0. Both return an error and zero data for a slot number that is out of range.
- R8: Op 3 returns the segment word of the matching slot, or all ones on a miss. When mode32 is high, A bits 63:32 are treated as zero for this lookup.
- R9: Op 4 clears the valid flag of slots 1 and above and leaves slot 0 valid. It pulses flush_local only if at least one of those slots was valid.
- R10: Op 5 clears the valid flag of the slot matching A. It pulses flush_global if cmd_global is high, otherwise flush_local. On a miss it requests no flush.
- R11: Each accepted command yields rsp_valid exactly one clock later. Op codes 6 and 7 return an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_1t | input | 1 | Allow 1 TB segments on write |
| mode32 | input | 1 | 32-bit addressing for op 3 |
| lk_addr | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Registered lookup hit |
| lk_slot | output | IW | Registered matching slot |
| lk_vsid | output | 64 | Registered segment word |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always high |
| cmd_op | input | 3 | Operation code |
| cmd_global | input | 1 | Global scope for op 5 |
| cmd_a | input | 64 | Operand A (slot/tag or address) |
| cmd_b | input | 64 | Operand B (segment word) |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Command rejected |
| rsp_data | output | 64 | Read or find result |
| flush_local | output | 1 | Local translation flush request |
| flush_global | output | 1 | Global translation flush request |

## Verification
The bench builds the block with NSLOTS=4 and a two-entry page-size table holding codes 0 and 5. With only four slots, an out-of-range slot number such as 4 or 5 is easy to reach. The same four slots are enough to hold an overlapping 1 TB and 256 MB pair, together with slot 0, so the invalidate-all exemption and the priority order can be observed directly. The short table makes code 3 an illegal page size.

// File: rtl/slb_array.sv
module slb_array #(
  parameter int NSLOTS = 32,
  parameter int NPS = 3,
  parameter logic [NPS*4-1:0] PS_CODES = {4'h5, 4'h1, 4'h0},
  localparam int IW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_1t,
  input  logic          mode32,
  input  logic [63:0]   lk_addr,
  output logic          lk_hit,
  output logic [IW-1:0] lk_slot,
  output logic [63:0]   lk_vsid,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_global,
  input  logic [63:0]   cmd_a,
  input  logic [63:0]   cmd_b,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [63:0]   rsp_data,
  output logic          flush_local,
  output logic          flush_global
);
  localparam int VB = 27;
  localparam logic [11:0] NS12 = 12'(NSLOTS);
  localparam logic [2:0] OP_WR = 3'd0, OP_RE = 3'd1, OP_RV = 3'd2,
                         OP_FIND = 3'd3, OP_IALL = 3'd4, OP_IADDR = 3'd5;

  logic [63:0] esid_q [NSLOTS];
  logic [63:0] vsid_q [NSLOTS];

  function automatic logic seg_match(input logic [63:0] es, input logic [63:0] vs,
                                     input logic [63:0] ad);
    logic [63:0] k256, k1t;
    k256 = {ad[63:28], 1'b1, 27'b0};
    k1t  = {ad[63:40], 12'b0, 1'b1, 27'b0};
    return ((es == k256) && (vs[63:62] == 2'd0)) ||
           ((es == k1t)  && (vs[63:62] == 2'd1));
  endfunction

  assign cmd_ready = 1'b1;

  logic [63:0] c_addr;
  assign c_addr = (cmd_op == OP_FIND && mode32) ? {32'b0, cmd_a[31:0]} : cmd_a;

  logic l_h, c_h, any_hi, ps_ok;
  logic [IW-1:0] l_i, c_i;
  always_comb begin
    l_h = 1'b0; l_i = '0; c_h = 1'b0; c_i = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (seg_match(esid_q[i], vsid_q[i], lk_addr)) begin l_h = 1'b1; l_i = IW'(i); end
      if (seg_match(esid_q[i], vsid_q[i], c_addr))  begin c_h = 1'b1; c_i = IW'(i); end
    end
    any_hi = 1'b0;
    for (int i = 1; i < NSLOTS; i++) any_hi = any_hi | esid_q[i][VB];
    ps_ok = 1'b0;
    for (int p = 0; p < NPS; p++) ps_ok = ps_ok | (cmd_b[7:4] == PS_CODES[p*4 +: 4]);
  end

  logic in_rng, wr_bad;
  logic [IW-1:0] sl;
  assign in_rng = cmd_a[11:0] < NS12;
  assign sl     = cmd_a[IW-1:0];
  assign wr_bad = !in_rng || (|cmd_a[26:12]) || cmd_b[63] || (cmd_b[62] && !en_1t) || !ps_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOTS; i++) begin
        esid_q[i] <= '0;
        vsid_q[i] <= '0;
      end
      lk_hit <= 1'b0; lk_slot <= '0; lk_vsid <= '0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_data <= '0;
      flush_local <= 1'b0; flush_global <= 1'b0;
    end else begin
      lk_hit  <= l_h;
      lk_slot <= l_h ? l_i : '0;
      lk_vsid <= l_h ? vsid_q[l_i] : '0;
      rsp_valid <= cmd_valid;
      rsp_err <= 1'b0; rsp_data <= '0;
      flush_local <= 1'b0; flush_global <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_WR:
            if (wr_bad) rsp_err <= 1'b1;
            else begin
              esid_q[sl] <= {cmd_a[63:12], 12'b0};
              vsid_q[sl] <= cmd_b;
            end
          OP_RE, OP_RV:
            if (!in_rng) rsp_err <= 1'b1;
            else rsp_data <= (cmd_op == OP_RE) ? esid_q[sl] : vsid_q[sl];
          OP_FIND:
            rsp_data <= c_h ? vsid_q[c_i] : '1;
          OP_IALL: begin
            for (int i = 1; i < NSLOTS; i++) esid_q[i][VB] <= 1'b0;
            flush_local <= any_hi;
          end
          OP_IADDR:
            if (c_h) begin
              esid_q[c_i][VB] <= 1'b0;
              flush_local  <= !cmd_global;
              flush_global <= cmd_global;
            end
          default: rsp_err <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk #(
  parameter int NSLOTS = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        cmd_global,
  input logic [63:0] cmd_a,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        flush_local,
  input logic        flush_global
);
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_valid) && !$past(rst)) |-> rsp_valid);

  a_r10_one_flush: assert property (@(posedge clk) disable iff (rst)
    !(flush_local && flush_global));

  a_r10_global_src: assert property (@(posedge clk) disable iff (rst)
    flush_global |-> ($past(cmd_global) && $past(cmd_op) == 3'd5 && rsp_valid));

  a_r5_range_reject: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(cmd_op) == 3'd0 && {20'b0, $past(cmd_a[11:0])} >= NSLOTS) |-> rsp_err);

  a_r9_invall_local: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(cmd_op) == 3'd4) |-> (!flush_global && !rsp_err));
endmodule

bind slb_array slb_array_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_global(cmd_global), .cmd_a(cmd_a), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .flush_local(flush_local), .flush_global(flush_global)
);

// File: tb/sim_slb_array.sv
`timescale 1ns/1ps
module sim_slb_array;
  localparam int NS = 4;
  localparam int IW = 2;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst = 1, en_1t = 1, mode32 = 0;
  logic [63:0] lk_addr = '0, cmd_a = '0, cmd_b = '0;
  logic cmd_valid = 0, cmd_global = 0;
  logic [2:0] cmd_op = '0;
  logic lk_hit, cmd_ready, rsp_valid, rsp_err, flush_local, flush_global;
  logic [IW-1:0] lk_slot;
  logic [63:0] lk_vsid, rsp_data;

  always #10 clk = ~clk;

  slb_array #(.NSLOTS(NS), .NPS(2), .PS_CODES(8'h50)) u0 (
    .clk(clk), .rst(rst), .en_1t(en_1t), .mode32(mode32), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_vsid(lk_vsid),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_global(cmd_global), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .flush_local(flush_local), .flush_global(flush_global));

  typedef struct {
    logic [63:0] d;
    logic e, fl, fg;
    string tag;
  } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic g, input logic [63:0] d, input logic e,
                       input logic fl, input logic fg, input string tag);
    exp_t x;
    @(negedge clk);
    cmd_op = op; cmd_a = a; cmd_b = b; cmd_global = g; cmd_valid = 1;
    x.d = d; x.e = e; x.fl = fl; x.fg = fg; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic lk(input logic [63:0] addr, input logic h, input logic [IW-1:0] s,
                    input logic [63:0] v, input string tag);
    @(negedge clk);
    lk_addr = addr;
    @(posedge clk); #2;
    chk(lk_hit === h && lk_slot === s && lk_vsid === v, tag,
        {lk_hit, 61'b0, lk_slot} ^ lk_vsid, {h, 61'b0, s} ^ v);
  endtask

  always begin
    @(posedge clk); #2;
    if (rsp_valid) begin
      if (q.size() == 0) chk(0, "R11 unexpected response", rsp_data, '0);
      else begin
        exp_t x;
        x = q.pop_front();
        chk(rsp_data === x.d, {x.tag, " data"}, rsp_data, x.d);
        chk({rsp_err, flush_local, flush_global} === {x.e, x.fl, x.fg},
            {x.tag, " err/flush"}, {61'b0, rsp_err, flush_local, flush_global},
            {61'b0, x.e, x.fl, x.fg});
      end
    end
  end

  localparam logic [63:0] ESA = 64'h0000_0001_1800_0000, VS1 = 64'h0000_0000_00AB_C350;
  localparam logic [63:0] ES2 = 64'h0000_0300_0800_0000, VS2 = 64'h4000_0000_0000_7700;
  localparam logic [63:0] VS3 = 64'h0000_0000_0000_1150;
  localparam logic [63:0] ES0 = 64'h0000_0000_2800_0000, VS0 = 64'h0000_0000_0000_0A00;
  localparam logic [63:0] A1 = 64'h0000_0001_1234_5678, A2 = 64'h0000_03AB_CDEF_0123;
  localparam logic [63:0] A3 = 64'h0000_0300_0123_4567, A0 = 64'hABCD_0000_2345_6789;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    issue(1, 0, 0, 0, 0, 0, 0, 0, "R1 reset tag slot0");
    issue(2, 3, 0, 0, 0, 0, 0, 0, "R1 reset seg slot3");
    lk(A1, 0, 0, 0, "R1 reset lookup miss");
    issue(0, ESA | 1, VS1, 0, 0, 0, 0, 0, "R5 write slot1");
    issue(1, 1, 0, 0, ESA, 0, 0, 0, "R7 read tag slot1");
    issue(2, 1, 0, 0, VS1, 0, 0, 0, "R7 read seg slot1");
    lk(A1, 1, 1, VS1, "R2 lookup 256MB hit");
    lk(64'h0000_0001_2000_0000, 0, 0, 0, "R2 lookup neighbour miss");
    issue(0, ES2 | 2, VS2, 0, 0, 0, 0, 0, "R3 write 1TB slot2");
    lk(A2, 1, 2, VS2, "R3 lookup 1TB hit");
    issue(0, ES2 | 3, VS3, 0, 0, 0, 0, 0, "R4 write slot3");
    lk(A3, 1, 2, VS2, "R4 lowest slot wins");
    issue(0, ES0 | 4, VS0, 0, 0, 1, 0, 0, "R5 slot out of range");
    issue(0, ES0 | 64'h1000, VS0, 0, 0, 1, 0, 0, "R6 reserved tag bit");
    issue(0, ES0, 64'h8000_0000_0000_0050, 0, 0, 1, 0, 0, "R6 bad size");
    en_1t = 0;
    issue(0, ES0, VS2, 0, 0, 1, 0, 0, "R6 1TB disabled");
    en_1t = 1;
    issue(0, ES0, 64'h30, 0, 0, 1, 0, 0, "R6 unknown page code");
    issue(1, 0, 0, 0, 0, 0, 0, 0, "R6 slot0 untouched");
    lk(64'h0000_0000_2345_6789, 0, 0, 0, "R5 rejected write not visible");
    issue(1, 5, 0, 0, 0, 1, 0, 0, "R7 read tag out of range");
    issue(2, 4, 0, 0, 0, 1, 0, 0, "R7 read seg out of range");
    issue(0, ES0, VS0, 0, 0, 0, 0, 0, "R5 write slot0");
    issue(3, A1, 0, 0, VS1, 0, 0, 0, "R8 find hit");
    issue(3, 64'h0000_0009_0000_0000, 0, 0, ONES, 0, 0, 0, "R8 find miss");
    mode32 = 1;
    issue(3, A0, 0, 0, VS0, 0, 0, 0, "R8 find 32-bit mode");
    mode32 = 0;
    issue(3, A0, 0, 0, ONES, 0, 0, 0, "R8 find 64-bit mode miss");
    issue(5, A1, 0, 1, 0, 0, 0, 1, "R10 inval global");
    lk(A1, 0, 0, 0, "R10 slot1 gone");
    issue(5, A1, 0, 1, 0, 0, 0, 0, "R10 inval miss no flush");
    issue(5, A2, 0, 0, 0, 0, 1, 0, "R10 inval local");
    lk(A3, 1, 3, VS3, "R4 slot3 after slot2 cleared");
    issue(1, 2, 0, 0, 64'h0000_0300_0000_0000, 0, 0, 0, "R10 slot2 valid bit cleared");
    issue(4, 0, 0, 0, 0, 0, 1, 0, "R9 inval all");
    lk(A3, 0, 0, 0, "R9 slot3 gone");
    lk(64'h0000_0000_2345_6789, 1, 0, VS0, "R9 slot0 kept");
    issue(1, 3, 0, 0, 64'h0000_0300_0000_0000, 0, 0, 0, "R9 slot3 tag kept");
    issue(4, 0, 0, 0, 0, 0, 0, 0, "R9 inval all nothing valid");
    issue(7, 0, 0, 0, 0, 1, 0, 0, "R11 illegal op");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11 missing responses", 64'(q.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'(q.size()), 64'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule